// File: doc/BRIEF.md
# Pipe queue switcher with descriptor save and restore

This block is the queue-selection front end of one command execution pipe. The pipe owns several queue slots but runs exactly one of them at a time. The running queue's live registers sit in the pipe: an active flag, a base address, a read pointer and a write pointer. Every slot, running or not, also has a saved descriptor in an internal store. A descriptor holds the base, both pointers and a mapped flag.

Software-side agents map and unmap slots, and ring a doorbell that moves a slot's write pointer. Three triggers ask the pipe to move to another queue: a switch command from the command stream, a switch at the next packet boundary, and a scheduler request that names a target slot. Every switch runs the same sequence:
1. Drop the active flag.
2. Write the four descriptor fields of the outgoing queue to the store, one field per cycle.
3. Read the incoming queue's four fields back, one per cycle.
4. Raise the active flag again.

Fetch and packet decode are outside the block. The pipe offers a fetch address, and a packet-done strobe stands in for completion.

Top module: `pipe_qswitch`

## Requirements
- R1: After reset no queue is active, `busy`, `err` and `fetch_valid` are low, and no slot is mapped.
- R2: `fetch_valid` is high only while the active flag is set and the read pointer differs from the write pointer. `fetch_addr` equals base plus read pointer. Each `pkt_done` while fetch is valid advances the read pointer by one.
- R3: A map request loads the slot's descriptor with the given base, both pointers zero and the mapped flag set. A doorbell sets a slot's write pointer. Map, unmap and doorbell requests that arrive while `busy` is high are ignored.
- R4: While no queue runs, the pipe starts on its own the first mapped slot with unread work, searching round-robin from the slot after the last one run. The start restores the descriptor and then raises the active flag, with `busy` high for exactly 5 cycles.
- R5: A switch away from a running queue keeps `busy` high for exactly 9 cycles: 4 save, 4 restore and 1 activate. The active flag is low during every one of those cycles, and no store write occurs while the flag is high.
- R6: A resumed queue continues with the base, read pointer and write pointer it held when it was switched out.
- R7: Among requests in the same cycle, unmap wins over a scheduler request, which wins over a command-stream switch, which wins over a packet-boundary switch.
- R8: Command-stream and packet-boundary switches go to the next slot after the running one, in round-robin order, that is mapped and has unread work. If no such slot exists, the request is ignored and `busy` stays low.
- R9: A packet-boundary switch keeps the queue active, with `busy` high, until `pkt_done` arrives or the queue runs dry. Only then does the save start.
- R10: A scheduler request naming an unmapped slot produces a single-cycle `err` pulse and causes no switch. A request naming the running slot is ignored.
- R11: Unmapping the running slot saves it with the mapped flag cleared, then switches to a round-robin candidate, or goes idle after 4 busy cycles when there is none. Unmapping any other slot clears its mapped flag in the next cycle.
- R12: A map request aimed at the running slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_switch | input | 1 | Switch command from the command stream |
| pkt_switch | input | 1 | Switch at the next packet boundary |
| pkt_done | input | 1 | Current packet completed |
| sched_req | input | 1 | External scheduler switch request |
| sched_slot | input | QW | Target slot of the scheduler request |
| map_valid | input | 1 | Map a slot |
| map_slot | input | QW | Slot to map |
| map_base | input | AW | Base address for the mapped slot |
| unmap_valid | input | 1 | Unmap a slot |
| unmap_slot | input | QW | Slot to unmap |
| db_valid | input | 1 | Doorbell write |
| db_slot | input | QW | Doorbell slot |
| db_wptr | input | PW | New write pointer |
| run_active | output | 1 | Active flag of the running slot |
| run_slot | output | QW | Slot held in the pipe registers |
| run_base | output | AW | Live base address |
| run_rptr | output | PW | Live read pointer |
| run_wptr | output | PW | Live write pointer |
| fetch_valid | output | 1 | Work available to fetch |
| fetch_addr | output | AW | Address of the next packet |
| busy | output | 1 | Switch sequence in progress |
| err | output | 1 | Rejected scheduler request |
| queue_mapped | output | NQ | Mapped flag of each slot |

## Verification
A corrupted field in the save or restore path does not show up until the victim queue runs again. When that queue next raises its active flag, `run_base`, `run_rptr` or `run_wptr` differ from what was left behind. The scoreboard catches this on the first activation edge, often many switches later. A broken sequencing state shows within one switch: `busy` stays high for the wrong number of cycles, or `run_active` is high while `busy` is high outside a packet wait. A wrong round-robin or priority decision shows on the very next activation as an unexpected `run_slot`.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RUN, S_PWAIT, S_SAVE, S_RESTORE, S_ACT
    } qsw_state_e;

    // descriptor field order used by both save and restore
    localparam logic [1:0] FLD_BASE = 2'd0;
    localparam logic [1:0] FLD_RPTR = 2'd1;
    localparam logic [1:0] FLD_WPTR = 2'd2;
    localparam logic [1:0] FLD_MAP  = 2'd3;
endpackage

// File: rtl/qsw_rr_pick.sv
module qsw_rr_pick #(
    parameter int NQ = 2,
    parameter int QW = 1
) (
    input  logic [NQ-1:0] elig,
    input  logic [QW-1:0] start,
    input  logic          incl_start,
    output logic          found,
    output logic [QW-1:0] pick
);
    // first eligible slot after start, wrapping; start itself only if incl_start
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = start;
        for (int k = NQ; k >= 1; k--) begin
            idx = (int'(start) + k) % NQ;
            if (elig[idx] && (incl_start || idx != int'(start))) begin
                found = 1'b1;
                pick  = idx[QW-1:0];
            end
        end
    end
endmodule

// File: rtl/qsw_desc_store.sv
module qsw_desc_store
    import qsw_pkg::*;
#(
    parameter int NQ = 2,
    parameter int QW = 1,
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          db_en,
    input  logic [QW-1:0] db_slot,
    input  logic [PW-1:0] db_wptr,
    input  logic          map_en,
    input  logic [QW-1:0] map_slot,
    input  logic [AW-1:0] map_base,
    input  logic          unmap_en,
    input  logic [QW-1:0] unmap_slot,
    input  logic          st_valid,
    input  logic          st_write,
    input  logic [QW-1:0] st_slot,
    input  logic [1:0]    st_field,
    input  logic [AW-1:0] st_wdata,
    output logic          st_ready,
    output logic [AW-1:0] st_rdata,
    output logic [NQ-1:0] mapped_o,
    output logic [NQ-1:0] nonempty_o
);
    typedef struct packed {
        logic          mapped;
        logic [AW-1:0] base;
        logic [PW-1:0] rptr;
        logic [PW-1:0] wptr;
    } desc_t;

    desc_t ent_d [NQ];
    desc_t ent_q [NQ];

    assign st_ready = 1'b1;

    always_comb begin
        ent_d = ent_q;
        if (db_en)
            ent_d[db_slot].wptr = db_wptr;
        if (map_en)
            ent_d[map_slot] = '{mapped: 1'b1, base: map_base, rptr: '0, wptr: '0};
        if (unmap_en)
            ent_d[unmap_slot].mapped = 1'b0;
        if (st_valid && st_ready && st_write) begin
            case (st_field)
                FLD_BASE: ent_d[st_slot].base   = st_wdata;
                FLD_RPTR: ent_d[st_slot].rptr   = st_wdata[PW-1:0];
                FLD_WPTR: ent_d[st_slot].wptr   = st_wdata[PW-1:0];
                default:  ent_d[st_slot].mapped = st_wdata[0];
            endcase
        end
    end

    always_comb begin
        case (st_field)
            FLD_BASE: st_rdata = ent_q[st_slot].base;
            FLD_RPTR: st_rdata = AW'(ent_q[st_slot].rptr);
            FLD_WPTR: st_rdata = AW'(ent_q[st_slot].wptr);
            default:  st_rdata = AW'(ent_q[st_slot].mapped);
        endcase
    end

    for (genvar g = 0; g < NQ; g++) begin : g_view
        assign mapped_o[g]   = ent_q[g].mapped;
        assign nonempty_o[g] = ent_q[g].mapped && (ent_q[g].rptr != ent_q[g].wptr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) ent_q[i] <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end
endmodule

// File: rtl/pipe_qswitch.sv
module pipe_qswitch
    import qsw_pkg::*;
#(
    parameter int NQ = 2,
    parameter int AW = 16,
    parameter int PW = 8,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_switch,
    input  logic          pkt_switch,
    input  logic          pkt_done,
    input  logic          sched_req,
    input  logic [QW-1:0] sched_slot,
    input  logic          map_valid,
    input  logic [QW-1:0] map_slot,
    input  logic [AW-1:0] map_base,
    input  logic          unmap_valid,
    input  logic [QW-1:0] unmap_slot,
    input  logic          db_valid,
    input  logic [QW-1:0] db_slot,
    input  logic [PW-1:0] db_wptr,
    output logic          run_active,
    output logic [QW-1:0] run_slot,
    output logic [AW-1:0] run_base,
    output logic [PW-1:0] run_rptr,
    output logic [PW-1:0] run_wptr,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    output logic          busy,
    output logic          err,
    output logic [NQ-1:0] queue_mapped
);
    typedef struct packed {
        qsw_state_e    st;
        logic          active;
        logic [QW-1:0] cur;
        logic [QW-1:0] tgt;
        logic          have_tgt;
        logic          unmap_cur;
        logic [1:0]    fld;
        logic [AW-1:0] base;
        logic [PW-1:0] rptr;
        logic [PW-1:0] wptr;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;

    logic          ctrl_ok, in_run;
    logic          db_en, map_en, unmap_en;
    logic          st_valid, st_write, st_ready;
    logic [1:0]    st_field;
    logic [QW-1:0] st_slot;
    logic [AW-1:0] st_wdata, st_rdata;
    logic [NQ-1:0] mapped_w, nonempty_w;
    logic          cand_found;
    logic [QW-1:0] cand;

    assign ctrl_ok  = (r_q.st == S_IDLE) || (r_q.st == S_RUN);
    assign in_run   = (r_q.st == S_RUN);
    assign db_en    = db_valid && ctrl_ok;
    assign map_en   = map_valid && ctrl_ok && !(in_run && map_slot == r_q.cur);
    assign unmap_en = unmap_valid && ctrl_ok && !(in_run && unmap_slot == r_q.cur);

    qsw_desc_store #(.NQ(NQ), .QW(QW), .AW(AW), .PW(PW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .db_en(db_en), .db_slot(db_slot), .db_wptr(db_wptr),
        .map_en(map_en), .map_slot(map_slot), .map_base(map_base),
        .unmap_en(unmap_en), .unmap_slot(unmap_slot),
        .st_valid(st_valid), .st_write(st_write), .st_slot(st_slot),
        .st_field(st_field), .st_wdata(st_wdata), .st_ready(st_ready),
        .st_rdata(st_rdata), .mapped_o(mapped_w), .nonempty_o(nonempty_w)
    );

    qsw_rr_pick #(.NQ(NQ), .QW(QW)) rr_i (
        .elig(nonempty_w), .start(r_q.cur), .incl_start(r_q.st == S_IDLE),
        .found(cand_found), .pick(cand)
    );

    always_comb begin
        r_d      = r_q;
        r_d.err  = 1'b0;
        st_valid = 1'b0;
        st_write = 1'b0;
        st_slot  = r_q.cur;
        st_field = r_q.fld;
        st_wdata = '0;

        // live pointer updates while the queue owns the pipe
        if (in_run && db_valid && db_slot == r_q.cur)
            r_d.wptr = db_wptr;
        if ((in_run || r_q.st == S_PWAIT) && pkt_done && r_q.active && r_q.rptr != r_q.wptr)
            r_d.rptr = r_q.rptr + PW'(1);

        case (r_q.st)
            S_IDLE: begin
                if (sched_req) begin
                    if (mapped_w[sched_slot]) begin
                        r_d.tgt = sched_slot;
                        r_d.fld = FLD_BASE;
                        r_d.st  = S_RESTORE;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end else if (cand_found) begin
                    r_d.tgt = cand;
                    r_d.fld = FLD_BASE;
                    r_d.st  = S_RESTORE;
                end
            end
            S_RUN: begin
                if (unmap_valid && unmap_slot == r_q.cur) begin
                    r_d.active    = 1'b0;
                    r_d.unmap_cur = 1'b1;
                    r_d.have_tgt  = cand_found;
                    r_d.tgt       = cand;
                    r_d.fld       = FLD_BASE;
                    r_d.st        = S_SAVE;
                end else if (unmap_valid) begin
                    r_d.st = S_RUN;   // unmap of another slot takes the cycle
                end else if (sched_req) begin
                    if (!mapped_w[sched_slot]) begin
                        r_d.err = 1'b1;
                    end else if (sched_slot != r_q.cur) begin
                        r_d.active   = 1'b0;
                        r_d.have_tgt = 1'b1;
                        r_d.tgt      = sched_slot;
                        r_d.fld      = FLD_BASE;
                        r_d.st       = S_SAVE;
                    end
                end else if (cs_switch && cand_found) begin
                    r_d.active   = 1'b0;
                    r_d.have_tgt = 1'b1;
                    r_d.tgt      = cand;
                    r_d.fld      = FLD_BASE;
                    r_d.st       = S_SAVE;
                end else if (pkt_switch && cand_found) begin
                    r_d.have_tgt = 1'b1;
                    r_d.tgt      = cand;
                    r_d.fld      = FLD_BASE;
                    if (pkt_done || r_q.rptr == r_q.wptr) begin
                        r_d.active = 1'b0;
                        r_d.st     = S_SAVE;
                    end else begin
                        r_d.st = S_PWAIT;
                    end
                end
            end
            S_PWAIT: begin
                if (pkt_done || r_q.rptr == r_q.wptr) begin
                    r_d.active = 1'b0;
                    r_d.st     = S_SAVE;
                end
            end
            S_SAVE: begin
                st_valid = 1'b1;
                st_write = 1'b1;
                case (r_q.fld)
                    FLD_BASE: st_wdata = r_q.base;
                    FLD_RPTR: st_wdata = AW'(r_q.rptr);
                    FLD_WPTR: st_wdata = AW'(r_q.wptr);
                    default:  st_wdata = AW'(!r_q.unmap_cur);
                endcase
                if (st_ready) begin
                    r_d.fld = r_q.fld + 2'd1;
                    if (r_q.fld == FLD_MAP) begin
                        r_d.unmap_cur = 1'b0;
                        r_d.st        = r_q.have_tgt ? S_RESTORE : S_IDLE;
                    end
                end
            end
            S_RESTORE: begin
                st_valid = 1'b1;
                st_slot  = r_q.tgt;
                if (st_ready) begin
                    r_d.fld = r_q.fld + 2'd1;
                    case (r_q.fld)
                        FLD_BASE: r_d.base = st_rdata;
                        FLD_RPTR: r_d.rptr = st_rdata[PW-1:0];
                        FLD_WPTR: r_d.wptr = st_rdata[PW-1:0];
                        default: begin
                            r_d.cur = r_q.tgt;
                            r_d.st  = S_ACT;
                        end
                    endcase
                end
            end
            S_ACT: begin
                r_d.active = 1'b1;
                r_d.st     = S_RUN;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_active   = r_q.active;
    assign run_slot     = r_q.cur;
    assign run_base     = r_q.base;
    assign run_rptr     = r_q.rptr;
    assign run_wptr     = r_q.wptr;
    assign fetch_valid  = r_q.active && (r_q.rptr != r_q.wptr);
    assign fetch_addr   = r_q.base + AW'(r_q.rptr);
    assign busy         = !ctrl_ok;
    assign err          = r_q.err;
    assign queue_mapped = mapped_w;

    // R5: the descriptor store is never written while the queue is active
    p_save_only_when_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_write) |-> !r_q.active);

    // R5: the active flag rises only out of the activate step after restore
    p_active_after_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.active) |-> ($past(r_q.st) == S_ACT));

    // R2: while a queue stays active its read pointer only steps by one
    p_rptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.active && $past(r_q.active) && r_q.rptr != $past(r_q.rptr))
            |-> (r_q.rptr == $past(r_q.rptr) + PW'(1)));

    // R9: a pending packet-boundary switch keeps the queue running
    p_pkt_wait_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PWAIT && !pkt_done && r_q.rptr != r_q.wptr) |=> r_q.active);

    // R10: a rejection never coincides with a switch in progress
    p_err_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

// File: tb/pipe_qswitch_tb_top.sv
`timescale 1ns/1ps
module pipe_qswitch_tb_top;
    localparam int NQ = 4;
    localparam int QW = 2;
    localparam int AW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_switch, pkt_switch, pkt_done, sched_req;
    logic [QW-1:0] sched_slot, map_slot, unmap_slot, db_slot;
    logic          map_valid, unmap_valid, db_valid;
    logic [AW-1:0] map_base;
    logic [PW-1:0] db_wptr;
    logic          run_active, fetch_valid, busy, err;
    logic [QW-1:0] run_slot;
    logic [AW-1:0] run_base, fetch_addr;
    logic [PW-1:0] run_rptr, run_wptr;
    logic [NQ-1:0] queue_mapped;

    always #4 clk = ~clk;   // 125 MHz

    pipe_qswitch #(.NQ(NQ), .AW(AW), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cs_switch(cs_switch), .pkt_switch(pkt_switch), .pkt_done(pkt_done),
        .sched_req(sched_req), .sched_slot(sched_slot),
        .map_valid(map_valid), .map_slot(map_slot), .map_base(map_base),
        .unmap_valid(unmap_valid), .unmap_slot(unmap_slot),
        .db_valid(db_valid), .db_slot(db_slot), .db_wptr(db_wptr),
        .run_active(run_active), .run_slot(run_slot), .run_base(run_base),
        .run_rptr(run_rptr), .run_wptr(run_wptr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .busy(busy), .err(err), .queue_mapped(queue_mapped)
    );

    typedef struct {
        int    slot;
        int    base;
        int    rptr;
        int    wptr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    bit   prev_act = 1'b0;

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic push(input int slot, input int base, input int rp, input int wp, input string req);
        exp_t e;
        e.slot = slot; e.base = base; e.rptr = rp; e.wptr = wp; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: every activation edge is compared with the next scoreboard item
    always @(negedge clk) begin
        if (rst_n) begin
            if (run_active && !prev_act) begin
                if (exp_q.size() == 0) begin
                    chk_eq("R6", "unexpected activation of slot", longint'(run_slot), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk_eq(e.req, "activated slot", longint'(run_slot), e.slot);
                    chk_eq(e.req, "restored base", longint'(run_base), e.base);
                    chk_eq(e.req, "restored rptr", longint'(run_rptr), e.rptr);
                    chk_eq(e.req, "restored wptr", longint'(run_wptr), e.wptr);
                end
            end
            prev_act = run_active;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_map(input int slot, input int base);
        map_valid = 1'b1; map_slot = QW'(slot); map_base = AW'(base);
        @(negedge clk);
        map_valid = 1'b0;
    endtask

    task automatic do_unmap(input int slot);
        unmap_valid = 1'b1; unmap_slot = QW'(slot);
        @(negedge clk);
        unmap_valid = 1'b0;
    endtask

    task automatic do_db(input int slot, input int wp);
        db_valid = 1'b1; db_slot = QW'(slot); db_wptr = PW'(wp);
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic do_pkt(input int n);
        repeat (n) begin
            pkt_done = 1'b1;
            @(negedge clk);
            pkt_done = 1'b0;
        end
    endtask

    task automatic do_cs();
        cs_switch = 1'b1;
        @(negedge clk);
        cs_switch = 1'b0;
    endtask

    task automatic do_sched(input int slot);
        sched_req = 1'b1; sched_slot = QW'(slot);
        @(negedge clk);
        sched_req = 1'b0;
    endtask

    task automatic wait_switch(input int exp_cnt, input string req);
        int t = 0;
        int n = 0;
        int hot = 0;
        while (!busy && t < 20) begin @(negedge clk); t++; end
        while (busy && n < 200) begin
            if (run_active) hot++;
            n++;
            @(negedge clk);
        end
        if (exp_cnt >= 0) begin
            chk_eq(req, "busy cycles", n, exp_cnt);
            chk_eq(req, "cycles active during switch", hot, 0);
        end else begin
            chk_eq(req, "switch completed", longint'(busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cs_switch = 0; pkt_switch = 0; pkt_done = 0; sched_req = 0; sched_slot = '0;
        map_valid = 0; map_slot = '0; map_base = '0;
        unmap_valid = 0; unmap_slot = '0; db_valid = 0; db_slot = '0; db_wptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1", "run_active", run_active, 0);
        chk_eq("R1", "busy", busy, 0);
        chk_eq("R1", "err", err, 0);
        chk_eq("R1", "fetch_valid", fetch_valid, 0);
        chk_eq("R1", "queue_mapped", queue_mapped, 0);

        // R3 mapping; R4 no start while every mapped queue is empty
        do_map(1, 'h100);
        do_map(2, 'h200);
        cyc(3);
        chk_eq("R3", "queue_mapped", queue_mapped, 4'b0110);
        chk_eq("R4", "idle with empty queues", run_active, 0);

        // R4 idle start on doorbell
        push(2, 'h200, 0, 5, "R4");
        do_db(2, 5);
        wait_switch(5, "R4");
        chk_eq("R2", "fetch_valid", fetch_valid, 1);
        chk_eq("R2", "fetch_addr", fetch_addr, 'h200);
        do_pkt(2);
        chk_eq("R2", "rptr after two packets", run_rptr, 2);
        chk_eq("R2", "fetch_addr after two packets", fetch_addr, 'h202);

        // R5 command-stream switch with full save and restore
        do_db(1, 3);
        push(1, 'h100, 0, 3, "R5");
        do_cs();
        wait_switch(9, "R5");
        do_pkt(1);
        chk_eq("R2", "rptr slot 1", run_rptr, 1);

        // R9 packet-boundary switch waits for pkt_done; R6 slot 2 resumes
        push(2, 'h200, 2, 5, "R6");
        pkt_switch = 1'b1;
        @(negedge clk);
        pkt_switch = 1'b0;
        cyc(3);
        chk_eq("R9", "busy while waiting", busy, 1);
        chk_eq("R9", "still active while waiting", run_active, 1);
        chk_eq("R9", "slot while waiting", run_slot, 1);
        do_pkt(1);
        wait_switch(-1, "R9");
        chk_eq("R6", "resumed slot", run_slot, 2);

        // R10 scheduler request to an unmapped slot
        do_sched(3);
        chk_eq("R10", "err pulse", err, 1);
        chk_eq("R10", "no switch on reject", busy, 0);
        cyc(1);
        chk_eq("R10", "err single cycle", err, 0);
        do_sched(2);
        cyc(2);
        chk_eq("R10", "request to running slot ignored", busy, 0);
        chk_eq("R10", "running slot kept", run_slot, 2);

        // R7 scheduler request beats command-stream switch; R3 map while busy ignored
        do_map(3, 'h300);
        do_db(3, 1);
        push(1, 'h100, 2, 3, "R7");
        sched_req = 1'b1; sched_slot = 2'd1; cs_switch = 1'b1;
        @(negedge clk);
        sched_req = 1'b0; cs_switch = 1'b0;
        do_map(0, 'h050);
        wait_switch(-1, "R7");
        chk_eq("R7", "priority winner", run_slot, 1);
        chk_eq("R3", "map while busy ignored", queue_mapped, 4'b1110);

        // R12 map of the running slot ignored
        do_map(1, 'h999);
        cyc(1);
        chk_eq("R12", "running base unchanged", run_base, 'h100);

        // R11 unmap of an idle slot
        do_unmap(3);
        chk_eq("R11", "slot 3 unmapped", queue_mapped, 4'b0110);

        // R8 round robin to next candidate
        push(2, 'h200, 2, 5, "R8");
        do_cs();
        wait_switch(9, "R8");

        // R11 unmap of the running slot switches on
        push(1, 'h100, 2, 3, "R11");
        do_unmap(2);
        wait_switch(9, "R11");
        chk_eq("R11", "slot 2 unmapped after save", queue_mapped, 4'b0010);

        // R8 no candidate: request ignored
        do_cs();
        cyc(2);
        chk_eq("R8", "no switch without candidate", busy, 0);
        chk_eq("R8", "slot kept", run_slot, 1);

        // R2 queue runs dry
        do_pkt(1);
        chk_eq("R2", "rptr at wptr", run_rptr, 3);
        chk_eq("R2", "fetch stops when empty", fetch_valid, 0);

        // R11 unmap of the last running slot goes idle
        do_unmap(1);
        wait_switch(4, "R11");
        chk_eq("R11", "idle after last unmap", run_active, 0);
        chk_eq("R11", "nothing mapped", queue_mapped, 0);

        cyc(2);
        chk_eq("R6", "scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule